// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits beside a memory array shared by two fully independent ports, called left and right. Each port has its own address, chip select, write strobe, output enable and a pair of byte enables for the upper and lower halves of the 16-bit word. When both ports are selected and present the same address, the block decides which port reached that address first. It then raises busy toward the other port and withholds that port's write strobes. Reads on the losing port still go ahead. Only a write by the opposite side can corrupt a shared location, and that write is the one being stopped.

A mode input chooses the role of the block. As master it arbitrates and drives a busy output for each side. As slave it drives no busy. It takes a busy input per side from a master instead and uses it only to block that side's writes. This lets several arrays be placed side by side to form a wider word, all following one decision. Arrival order is measured in clock cycles. A port counts as already present if it was selected on the same address in the previous cycle. When both ports arrive in the same cycle, the left port wins. A blocked write is dropped, not held for later.

Top module: `dp_collision_arbiter`

## Requirements
- R1: Neither busy output is high unless both chip selects are high and the two addresses are equal. Busy falls in the same cycle that the addresses differ or either select goes low.
- R2: In master mode, while the enabled addresses are equal, exactly one busy output is high. The two busy outputs are never high together.
- R3: When one port was already selected on an address in the previous cycle and the other port selects that address now, the newcomer receives busy and the earlier port does not.
- R4: When both ports select the same address in the same cycle, with neither present there before, the right port receives busy and the left port wins.
- R5: Once decided, the winner does not change while both selects stay high and both addresses stay unchanged.
- R6: In master mode, a busied port's write lanes are all zero. The winning port's write proceeds.
- R7: In slave mode, both busy outputs stay low. A high busy input of a port forces that port's write lanes to zero, and the opposite port's writes are unaffected.
- R8: Read lanes equal {upper, lower} byte enables whenever the port is selected, not writing, and output-enabled, regardless of busy.
- R9: Write lane bit 1 follows the upper byte enable and bit 0 follows the lower byte enable. Both are gated by select, write strobe and the absence of blocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1 = arbitrate and drive busy, 0 = accept busy inputs |
| cs_l | input | 1 | Left chip select, active high |
| wr_l | input | 1 | Left write strobe (1 = write, 0 = read) |
| oe_l | input | 1 | Left output enable, active high |
| ub_l | input | 1 | Left upper byte enable |
| lb_l | input | 1 | Left lower byte enable |
| addr_l | input | AW | Left address |
| busy_in_l | input | 1 | Left busy from a master (used in slave mode) |
| cs_r | input | 1 | Right chip select, active high |
| wr_r | input | 1 | Right write strobe (1 = write, 0 = read) |
| oe_r | input | 1 | Right output enable, active high |
| ub_r | input | 1 | Right upper byte enable |
| lb_r | input | 1 | Right lower byte enable |
| addr_r | input | AW | Right address |
| busy_in_r | input | 1 | Right busy from a master (used in slave mode) |
| busy_out_l | output | 1 | Busy toward the left port (master mode) |
| busy_out_r | output | 1 | Busy toward the right port (master mode) |
| wr_lane_l | output | 2 | Left byte write strobes {upper, lower} |
| wr_lane_r | output | 2 | Right byte write strobes {upper, lower} |
| rd_lane_l | output | 2 | Left byte read enables {upper, lower} |
| rd_lane_r | output | 2 | Right byte read enables {upper, lower} |

## Verification
The assertions assume that port inputs change only between clock edges, so the address and select seen at an edge describe the whole cycle. The persistence and arrival properties compare each port with its own previous cycle, and they are enabled only after the first edge out of reset. The bench changes every input just after the falling edge and samples one time unit later. It returns both ports to idle for a cycle between scenarios, so each scenario starts with no history of earlier collisions.

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          cs_l,
  input  logic          wr_l,
  input  logic          oe_l,
  input  logic          ub_l,
  input  logic          lb_l,
  input  logic [AW-1:0] addr_l,
  input  logic          busy_in_l,
  input  logic          cs_r,
  input  logic          wr_r,
  input  logic          oe_r,
  input  logic          ub_r,
  input  logic          lb_r,
  input  logic [AW-1:0] addr_r,
  input  logic          busy_in_r,
  output logic          busy_out_l,
  output logic          busy_out_r,
  output logic [1:0]    wr_lane_l,
  output logic [1:0]    wr_lane_r,
  output logic [1:0]    rd_lane_l,
  output logic [1:0]    rd_lane_r
);

  logic          q_cs_l, q_cs_r, q_match, q_right_won, seen;
  logic [AW-1:0] q_addr_l, q_addr_r;
  logic          match, held_l, held_r, cont, right_wins, block_l, block_r;

  assign match      = cs_l & cs_r & (addr_l == addr_r);
  assign held_l     = q_cs_l & (q_addr_l == addr_l);
  assign held_r     = q_cs_r & (q_addr_r == addr_r);
  assign cont       = q_match & held_l & held_r;
  assign right_wins = cont ? q_right_won : (held_r & ~held_l);

  assign busy_out_l = master & match & right_wins;
  assign busy_out_r = master & match & ~right_wins;

  assign block_l = master ? busy_out_l : busy_in_l;
  assign block_r = master ? busy_out_r : busy_in_r;

  assign wr_lane_l = {ub_l, lb_l} & {2{cs_l & wr_l & ~block_l}};
  assign wr_lane_r = {ub_r, lb_r} & {2{cs_r & wr_r & ~block_r}};
  assign rd_lane_l = {ub_l, lb_l} & {2{cs_l & ~wr_l & oe_l}};
  assign rd_lane_r = {ub_r, lb_r} & {2{cs_r & ~wr_r & oe_r}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_cs_l      <= 1'b0;
      q_cs_r      <= 1'b0;
      q_addr_l    <= '0;
      q_addr_r    <= '0;
      q_match     <= 1'b0;
      q_right_won <= 1'b0;
      seen        <= 1'b0;
    end else begin
      q_cs_l      <= cs_l;
      q_cs_r      <= cs_r;
      q_addr_l    <= addr_l;
      q_addr_r    <= addr_r;
      q_match     <= match;
      q_right_won <= match & right_wins;
      seen        <= 1'b1;
    end
  end

  a_r1_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_out_l || busy_out_r) |-> (cs_l && cs_r && addr_l == addr_r));

  a_r2_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_out_l && busy_out_r));

  a_r2_one_when_match: assert property (@(posedge clk) disable iff (!rst_n)
    (master && cs_l && cs_r && addr_l == addr_r) |-> (busy_out_l != busy_out_r));

  a_r3_earlier_right_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && master && cs_l && cs_r && addr_l == addr_r &&
     $past(cs_r) && $past(addr_r) == addr_r &&
     !($past(cs_l) && $past(addr_l) == addr_l)) |-> (busy_out_l && !busy_out_r));

  a_r5_winner_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(busy_out_l) && master && cs_l && cs_r &&
     $stable(addr_l) && $stable(addr_r)) |-> busy_out_l);

  a_r6_busied_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_out_l |-> wr_lane_l == 2'b00) and (busy_out_r |-> wr_lane_r == 2'b00));

  a_r7_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (!busy_out_l && !busy_out_r));

  a_r7_slave_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && busy_in_r) |-> wr_lane_r == 2'b00);

endmodule

// File: tb/dp_collision_arbiter_test.sv
module dp_collision_arbiter_test;
  localparam int AW = 14;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, master = 1'b1;
  logic cs_l = 0, wr_l = 0, oe_l = 0, ub_l = 0, lb_l = 0, busy_in_l = 0;
  logic cs_r = 0, wr_r = 0, oe_r = 0, ub_r = 0, lb_r = 0, busy_in_r = 0;
  logic [AW-1:0] addr_l = '0, addr_r = '0;
  logic busy_out_l, busy_out_r;
  logic [1:0] wr_lane_l, wr_lane_r, rd_lane_l, rd_lane_r;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_collision_arbiter #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .master(master),
    .cs_l(cs_l), .wr_l(wr_l), .oe_l(oe_l), .ub_l(ub_l), .lb_l(lb_l),
    .addr_l(addr_l), .busy_in_l(busy_in_l),
    .cs_r(cs_r), .wr_r(wr_r), .oe_r(oe_r), .ub_r(ub_r), .lb_r(lb_r),
    .addr_r(addr_r), .busy_in_r(busy_in_r),
    .busy_out_l(busy_out_l), .busy_out_r(busy_out_r),
    .wr_lane_l(wr_lane_l), .wr_lane_r(wr_lane_r),
    .rd_lane_l(rd_lane_l), .rd_lane_r(rd_lane_r));

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_l(input logic c, w, o, u, b, input logic [AW-1:0] a);
    cs_l = c; wr_l = w; oe_l = o; ub_l = u; lb_l = b; addr_l = a;
  endtask

  task automatic set_r(input logic c, w, o, u, b, input logic [AW-1:0] a);
    cs_r = c; wr_r = w; oe_r = o; ub_r = u; lb_r = b; addr_r = a;
  endtask

  task automatic idle();
    @(negedge clk);
    set_l(0, 0, 0, 0, 0, '0);
    set_r(0, 0, 0, 0, 0, '0);
    busy_in_l = 0; busy_in_r = 0;
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset busy", {busy_out_l, busy_out_r}, 2'b00);
    chk("R9 reset wr_l", wr_lane_l, 2'b00);
    chk("R9 reset wr_r", wr_lane_r, 2'b00);
  endtask

  task automatic t_no_match();
    idle();
    @(negedge clk);
    set_l(1, 1, 0, 1, 1, 14'h0100);
    set_r(1, 1, 0, 1, 1, 14'h0101); #1;
    chk("R1 distinct addr busy", {busy_out_l, busy_out_r}, 2'b00);
    chk("R9 distinct wr_l", wr_lane_l, 2'b11);
    chk("R9 distinct wr_r", wr_lane_r, 2'b11);
  endtask

  task automatic t_left_first();
    idle();
    @(negedge clk);
    set_l(1, 1, 0, 1, 1, 14'h0200); #1;
    chk("R1 lone port busy", {busy_out_l, busy_out_r}, 2'b00);
    @(negedge clk);
    set_r(1, 1, 0, 1, 1, 14'h0200); #1;
    chk("R3 left earlier busy", {busy_out_l, busy_out_r}, 2'b01);
    chk("R6 winner left writes", wr_lane_l, 2'b11);
    chk("R6 loser right blocked", wr_lane_r, 2'b00);
    @(negedge clk); #1;
    chk("R5 left still wins", {busy_out_l, busy_out_r}, 2'b01);
    @(negedge clk);
    addr_r = 14'h0201; #1;
    chk("R1 mismatch drops busy", {busy_out_l, busy_out_r}, 2'b00);
    chk("R6 right writes again", wr_lane_r, 2'b11);
    @(negedge clk);
    addr_r = 14'h0200; #1;
    chk("R3 right returns late", {busy_out_l, busy_out_r}, 2'b01);
    @(negedge clk);
    cs_l = 0; #1;
    chk("R1 opposite deselect drops", {busy_out_l, busy_out_r}, 2'b00);
  endtask

  task automatic t_right_first();
    idle();
    @(negedge clk);
    set_r(1, 1, 0, 1, 1, 14'h3FFF); #1;
    @(negedge clk);
    set_l(1, 1, 0, 1, 1, 14'h3FFF); #1;
    chk("R3 right earlier busy", {busy_out_l, busy_out_r}, 2'b10);
    chk("R6 loser left blocked", wr_lane_l, 2'b00);
    chk("R6 winner right writes", wr_lane_r, 2'b11);
    @(negedge clk); #1;
    chk("R5 right still wins", {busy_out_l, busy_out_r}, 2'b10);
    @(negedge clk); #1;
    chk("R2 one busy", {busy_out_l, busy_out_r}, 2'b10);
  endtask

  task automatic t_tie();
    idle();
    @(negedge clk);
    set_l(1, 1, 0, 1, 1, 14'h0042);
    set_r(1, 1, 0, 1, 1, 14'h0042); #1;
    chk("R4 tie left wins", {busy_out_l, busy_out_r}, 2'b01);
    @(negedge clk); #1;
    chk("R5 tie decision held", {busy_out_l, busy_out_r}, 2'b01);
    @(negedge clk);
    addr_l = 14'h0043; addr_r = 14'h0043; #1;
    chk("R4 joint move is new tie", {busy_out_l, busy_out_r}, 2'b01);
  endtask

  task automatic t_read_busied();
    idle();
    @(negedge clk);
    set_l(1, 1, 0, 1, 1, 14'h0777); #1;
    @(negedge clk);
    set_r(1, 0, 1, 1, 1, 14'h0777); #1;
    chk("R2 read collision busy", {busy_out_l, busy_out_r}, 2'b01);
    chk("R8 busied read proceeds", rd_lane_r, 2'b11);
    chk("R6 winner write", wr_lane_l, 2'b11);
  endtask

  task automatic t_bytes();
    idle();
    @(negedge clk);
    set_l(1, 1, 0, 1, 0, 14'h0010);
    set_r(1, 1, 0, 0, 1, 14'h0020); #1;
    chk("R9 upper only", wr_lane_l, 2'b10);
    chk("R9 lower only", wr_lane_r, 2'b01);
    @(negedge clk);
    set_l(1, 0, 1, 0, 1, 14'h0010); #1;
    chk("R8 lower read lane", rd_lane_l, 2'b01);
    chk("R9 read no write", wr_lane_l, 2'b00);
  endtask

  task automatic t_slave();
    idle();
    @(negedge clk);
    master = 0;
    set_l(1, 1, 0, 1, 1, 14'h0500);
    set_r(1, 1, 0, 1, 1, 14'h0500); #1;
    chk("R7 slave no busy out", {busy_out_l, busy_out_r}, 2'b00);
    chk("R7 slave left writes", wr_lane_l, 2'b11);
    chk("R7 slave right writes", wr_lane_r, 2'b11);
    @(negedge clk);
    busy_in_l = 1; #1;
    chk("R7 busy_in blocks left", wr_lane_l, 2'b00);
    chk("R7 right unaffected", wr_lane_r, 2'b11);
    @(negedge clk);
    busy_in_l = 0; busy_in_r = 1; #1;
    chk("R7 busy_in blocks right", wr_lane_r, 2'b00);
    chk("R7 left unaffected", wr_lane_l, 2'b11);
    idle();
    master = 1;
  endtask

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_no_match();
    t_left_first();
    t_right_first();
    t_tie();
    t_read_busied();
    t_bytes();
    t_slave();
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule